// File: doc/BRIEF.md
# Interrupt Acknowledgment Latency Sequencer

This block sits between raw interrupt request pins and a short in-order pipeline. It brings each request line into the core clock domain and applies a per-class admission delay. It then runs a fixed four-cycle acknowledgment sequence. During that sequence it tells the pipeline to throw away whatever currently occupies the fetch and decode slots. In the cycle after the sequence it sends the pipeline a one-cycle redirect carrying the start address of the service routine.

Three request classes are supported, one pin each:
- **Direct line.** Taken on its synchronized rising edge.
- **Filtered line.** Must stay high for a programmable number of cycles before it counts.
- **Timer-captured line.** Passes the same filter, then waits a further capture delay. That delay is short or long depending on a prescaler select input.

The core can hold off acknowledgment with two inputs. It drops a "sampling allowed" flag during low-power modes or back-to-back non-sampling instructions. It raises a busy flag during long external bus transfers. A request that arrives while a sequence is running is remembered and served afterwards. Each redirect comes with a count of how many cycles the sequencer spent between taking the request and finishing acknowledgment. A checker uses this count to verify response bounds.

Top module: `irq_ack_seq`

## Requirements
- R1: While `rst` is high and in the cycle after it, `flush_if`, `flush_id` and `redirect` are 0, and `redirect_pc` and `ack_lat` are 0.
- R2: Every acknowledgment holds `flush_if` and `flush_id` high for exactly four consecutive cycles. `redirect` is high for exactly one cycle, immediately after the fourth, and never together with a flush.
- R3: With nothing blocking, a rising `irq_direct` first sampled at clock edge k produces `redirect` after edge k+6: two synchronizer stages plus four acknowledgment cycles. `ack_lat` reads 4.
- R4: `irq_filt` is accepted only after it has been sampled high on FILT_LEN+1 consecutive edges, so its response is FILT_LEN cycles later than a direct request. A pulse sampled high on FILT_LEN or fewer edges produces no redirect.
- R5: `irq_timer` passes the same filter and then waits a capture delay before entering the sequencer. The delay is 2 cycles when `tmr_fast_sel` is 1 and 4 cycles when it is 0, sampled at filter acceptance. With FILT_LEN=3, the response is edge k+11 or k+13.
- R6: Acknowledgment cannot start in a cycle where `sample_ok` is 0 or `bus_busy` is 1. Each such cycle from the request's arrival onward adds one cycle to the response. `ack_lat` then reads 4 plus the number of those cycles, so up to three of them keep it at or below 7.
- R7: A request that arrives while a sequence is running is never lost. Its own four-cycle sequence starts one idle cycle after the preceding redirect, so its redirect follows exactly six cycles later.
- R8: `redirect_pc` equals VEC_BASE + class × VEC_STRIDE, with class 0 = direct, 1 = filtered, 2 = timer. When several classes arrive in the same cycle, the lower class number is served first.
- R9: A request line held high generates one request only. A new request needs the line to fall and rise again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_direct | input | 1 | Direct request pin, asynchronous |
| irq_filt | input | 1 | Request pin through the digital filter, asynchronous |
| irq_timer | input | 1 | Timer-capture request pin, asynchronous |
| tmr_fast_sel | input | 1 | Prescaler select: 1 gives a 2-cycle capture delay, 0 gives 4 |
| sample_ok | input | 1 | Core allows interrupt sampling this cycle |
| bus_busy | input | 1 | Long external bus access in progress |
| flush_if | output | 1 | Invalidate the instruction in the fetch slot |
| flush_id | output | 1 | Invalidate the instruction in the decode slot |
| redirect | output | 1 | One-cycle strobe to fetch from `redirect_pc` |
| redirect_pc | output | AW | Service routine start address, zero when `redirect` is low |
| ack_lat | output | LW | Cycles from request take-up to the end of acknowledgment, valid with `redirect` |

## Verification
The properties assume that `sample_ok` and `bus_busy` change only between clock edges and never carry X after reset. The stimulus meets this by driving every input on the falling edge. The properties also assume that the admission stage never issues a second arrival for a class before the first has been taken. The stimulus respects this by leaving each request line low for many cycles between pulses, well beyond the filter and capture windows. Blocking windows are kept short enough that `ack_lat` stays well below its saturation value.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;

    localparam int NCLS = 3;

    typedef enum logic [1:0] {
        CLS_DIRECT = 2'd0,
        CLS_FILT   = 2'd1,
        CLS_TIMER  = 2'd2
    } irq_cls_e;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_WAIT = 3'd1,
        ST_INT1 = 3'd2,
        ST_INT2 = 3'd3,
        ST_INT3 = 3'd4,
        ST_INT4 = 3'd5,
        ST_VEC  = 3'd6
    } ack_st_e;

    // capture delay after filter acceptance for the timer class
    function automatic logic [2:0] tmr_delay(input logic fast);
        return fast ? 3'd2 : 3'd4;
    endfunction

    // fixed order: lowest class number wins
    function automatic irq_cls_e pick_class(input logic [NCLS-1:0] v);
        if (v[0])      return CLS_DIRECT;
        else if (v[1]) return CLS_FILT;
        else           return CLS_TIMER;
    endfunction

    function automatic logic in_ack(input ack_st_e s);
        return (s == ST_INT1) || (s == ST_INT2) || (s == ST_INT3) || (s == ST_INT4);
    endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] din,
    output logic [N-1:0] q
);
    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_line
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], din[i]};
            end
            assign q[i] = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/irq_class_gate.sv
module irq_class_gate
    import irq_ack_pkg::*;
#(
    parameter int FILT_LEN = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NCLS-1:0] lvl,
    input  logic            tmr_fast_sel,
    output logic [NCLS-1:0] arrive
);
    localparam int CW = $clog2(FILT_LEN + 2);
    localparam logic [CW-1:0] F_ACC = CW'(FILT_LEN);
    localparam logic [CW-1:0] F_TOP = CW'(FILT_LEN + 1);

    logic [NCLS-1:0] accepted;

    genvar i;
    generate
        for (i = 0; i < NCLS; i++) begin : g_cls
            if (i == int'(CLS_DIRECT)) begin : g_edge
                logic prev;
                always_ff @(posedge clk) begin
                    if (rst) prev <= 1'b0;
                    else     prev <= lvl[i];
                end
                assign accepted[i] = lvl[i] & ~prev;
            end else begin : g_filt
                // run-length counter, saturating one past the accept point
                logic [CW-1:0] run;
                always_ff @(posedge clk) begin
                    if (rst || !lvl[i])  run <= '0;
                    else if (run != F_TOP) run <= run + 1'b1;
                end
                assign accepted[i] = lvl[i] && (run == F_ACC);
            end
        end
    endgenerate

    logic [2:0] cap_cnt;
    always_ff @(posedge clk) begin
        if (rst)                          cap_cnt <= '0;
        else if (accepted[CLS_TIMER])     cap_cnt <= tmr_delay(tmr_fast_sel);
        else if (cap_cnt != 3'd0)         cap_cnt <= cap_cnt - 3'd1;
    end

    always_comb begin
        arrive             = accepted;
        arrive[CLS_TIMER]  = (cap_cnt == 3'd1);
    end
endmodule

// File: rtl/irq_ack_fsm.sv
module irq_ack_fsm
    import irq_ack_pkg::*;
#(
    parameter int LW = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NCLS-1:0] arrive,
    input  logic            blocked,
    output ack_st_e         state,
    output irq_cls_e        cls,
    output logic [LW-1:0]   lat
);
    logic [NCLS-1:0] pend_q, cand, grant_mask;
    ack_st_e         st_n;
    irq_cls_e        pick;
    logic            take;

    assign cand       = pend_q | arrive;
    assign pick       = pick_class(cand);
    assign take       = (state == ST_IDLE) && (|cand);
    assign grant_mask = take ? (NCLS'(1) << pick) : '0;

    always_comb begin
        st_n = state;
        unique case (state)
            ST_IDLE: if (take) st_n = blocked ? ST_WAIT : ST_INT1;
            ST_WAIT: if (!blocked) st_n = ST_INT1;
            ST_INT1: st_n = ST_INT2;
            ST_INT2: st_n = ST_INT3;
            ST_INT3: st_n = ST_INT4;
            ST_INT4: st_n = ST_VEC;
            ST_VEC:  st_n = ST_IDLE;
            default: st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            pend_q <= '0;
            cls    <= CLS_DIRECT;
            lat    <= '0;
        end else begin
            state  <= st_n;
            pend_q <= cand & ~grant_mask;
            if (take) begin
                cls <= pick;
                lat <= LW'(1);
            end else if ((state == ST_WAIT || state == ST_INT1 ||
                          state == ST_INT2 || state == ST_INT3) && lat != '1) begin
                lat <= lat + 1'b1;
            end
        end
    end
endmodule

// File: rtl/irq_ack_seq.sv
module irq_ack_seq
    import irq_ack_pkg::*;
#(
    parameter int             AW         = 16,
    parameter int             LW         = 6,
    parameter int             FILT_LEN   = 3,
    parameter int             SYNC_STG   = 2,
    parameter logic [AW-1:0]  VEC_BASE   = 16'h0100,
    parameter logic [AW-1:0]  VEC_STRIDE = 16'h0010
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          irq_direct,
    input  logic          irq_filt,
    input  logic          irq_timer,
    input  logic          tmr_fast_sel,
    input  logic          sample_ok,
    input  logic          bus_busy,
    output logic          flush_if,
    output logic          flush_id,
    output logic          redirect,
    output logic [AW-1:0] redirect_pc,
    output logic [LW-1:0] ack_lat
);
    logic [NCLS-1:0] lvl, arrive;
    ack_st_e         state;
    irq_cls_e        cls;
    logic [LW-1:0]   lat;

    irq_sync #(.N(NCLS), .STAGES(SYNC_STG)) u_sync (
        .clk (clk),
        .rst (rst),
        .din ({irq_timer, irq_filt, irq_direct}),
        .q   (lvl)
    );

    irq_class_gate #(.FILT_LEN(FILT_LEN)) u_gate (
        .clk          (clk),
        .rst          (rst),
        .lvl          (lvl),
        .tmr_fast_sel (tmr_fast_sel),
        .arrive       (arrive)
    );

    irq_ack_fsm #(.LW(LW)) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .arrive  (arrive),
        .blocked (bus_busy | ~sample_ok),
        .state   (state),
        .cls     (cls),
        .lat     (lat)
    );

    assign flush_if    = in_ack(state);
    assign flush_id    = in_ack(state);
    assign redirect    = (state == ST_VEC);
    assign redirect_pc = redirect ? (VEC_BASE + AW'(VEC_STRIDE * AW'(cls))) : '0;
    assign ack_lat     = lat;
endmodule

// File: rtl/irq_ack_seq_chk.sv
module irq_ack_seq_chk #(
    parameter int            AW         = 16,
    parameter int            LW         = 6,
    parameter logic [AW-1:0] VEC_BASE   = 16'h0100,
    parameter logic [AW-1:0] VEC_STRIDE = 16'h0010
) (
    input logic          clk,
    input logic          rst,
    input logic          sample_ok,
    input logic          bus_busy,
    input logic          flush_if,
    input logic          redirect,
    input logic [AW-1:0] redirect_pc,
    input logic [LW-1:0] ack_lat
);
    // R2: four flush cycles, then the strobe
    p_ack_span_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(flush_if) |-> flush_if ##1 flush_if ##1 flush_if ##1 flush_if ##1 (!flush_if && redirect));

    // R2: strobe lasts one cycle
    p_strobe_once_r2: assert property (@(posedge clk) disable iff (rst)
        redirect |=> !redirect);

    // R6: no sequence starts out of a blocked cycle
    p_defer_r6: assert property (@(posedge clk) disable iff (rst)
        ((bus_busy || !sample_ok) && !flush_if) |=> !flush_if);

    // R6: reported latency never below the acknowledgment length
    p_lat_floor_r6: assert property (@(posedge clk) disable iff (rst)
        redirect |-> (ack_lat >= LW'(4)));

    // R8: only the three class vectors appear
    p_vec_set_r8: assert property (@(posedge clk) disable iff (rst)
        redirect |-> (redirect_pc == VEC_BASE ||
                      redirect_pc == VEC_BASE + VEC_STRIDE ||
                      redirect_pc == VEC_BASE + VEC_STRIDE + VEC_STRIDE));
endmodule

bind irq_ack_seq irq_ack_seq_chk #(
    .AW(AW), .LW(LW), .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .sample_ok   (sample_ok),
    .bus_busy    (bus_busy),
    .flush_if    (flush_if),
    .redirect    (redirect),
    .redirect_pc (redirect_pc),
    .ack_lat     (ack_lat)
);

// File: tb/irq_ack_seq_test.sv
module irq_ack_seq_test;
    localparam int          FILT = 3;
    localparam logic [15:0] BASE = 16'h0100;
    localparam logic [15:0] STR  = 16'h0010;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic irq_direct = 0, irq_filt = 0, irq_timer = 0;
    logic tmr_fast_sel = 0, sample_ok = 1, bus_busy = 0;
    logic flush_if, flush_id, redirect;
    logic [15:0] redirect_pc;
    logic [5:0]  ack_lat;

    always #10 clk = ~clk;

    irq_ack_seq uut (
        .clk(clk), .rst(rst), .irq_direct(irq_direct), .irq_filt(irq_filt),
        .irq_timer(irq_timer), .tmr_fast_sel(tmr_fast_sel), .sample_ok(sample_ok),
        .bus_busy(bus_busy), .flush_if(flush_if), .flush_id(flush_id),
        .redirect(redirect), .redirect_pc(redirect_pc), .ack_lat(ack_lat)
    );

    typedef struct {
        int          at;
        logic [15:0] pc;
        int          lat;
        string       req;
    } exp_t;

    exp_t q[$];
    int cyc = 0, vectors = 0, fails = 0, seen = 0;
    int run_if = 0, run_id = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic push(input int at, input int cls, input int lat, input string req);
        exp_t e;
        e.at = at; e.pc = BASE + 16'(cls) * STR; e.lat = lat; e.req = req;
        q.push_back(e);
    endtask

    task automatic set_line(input int line, input logic v);
        case (line)
            0: irq_direct = v;
            1: irq_filt   = v;
            default: irq_timer = v;
        endcase
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drop_all();
        irq_direct = 0; irq_filt = 0; irq_timer = 0;
    endtask

    // monitor: pops the scoreboard on every strobe
    always @(negedge clk) begin
        if (!rst) begin
            if (flush_if) run_if++;
            if (flush_id) run_id++;
            if (redirect) begin
                exp_t e;
                seen++;
                check("R2 flush_if run", run_if, 4);
                check("R2 flush_id run", run_id, 4);
                run_if = 0; run_id = 0;
                if (q.size() == 0) begin
                    check("R9 unexpected redirect", 1, 0);
                end else begin
                    e = q.pop_front();
                    check({e.req, " cycle"}, cyc, e.at);
                    check("R8 vector", int'(redirect_pc), int'(e.pc));
                    check({e.req, " ack_lat"}, int'(ack_lat), e.lat);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL R2 watchdog expired with %0d items outstanding", q.size());
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        int n, s0;
        idle(3);
        // R1 reset state
        check("R1 flush_if", int'(flush_if), 0);
        check("R1 redirect", int'(redirect), 0);
        check("R1 ack_lat", int'(ack_lat), 0);
        check("R1 redirect_pc", int'(redirect_pc), 0);
        rst = 0;
        idle(1);
        check("R1 flush_id after reset", int'(flush_id), 0);
        idle(4);

        // R3 direct, and R9 level held long
        s0 = seen; n = cyc;
        set_line(0, 1); push(n + 7, 0, 4, "R3");
        idle(20); drop_all(); idle(20);
        check("R9 single redirect per level", seen - s0, 1);

        // R4 filtered, accepted
        n = cyc; set_line(1, 1); push(n + 7 + FILT, 1, 4, "R4");
        idle(20); drop_all(); idle(20);

        // R4 filtered, too short
        s0 = seen;
        set_line(1, 1); idle(FILT); drop_all(); idle(25);
        check("R4 short pulse ignored", seen - s0, 0);

        // R5 timer, fast prescale
        tmr_fast_sel = 1; n = cyc;
        set_line(2, 1); push(n + 7 + FILT + 2, 2, 4, "R5 fast");
        idle(25); drop_all(); idle(20);

        // R5 timer, slow prescale
        tmr_fast_sel = 0; n = cyc;
        set_line(2, 1); push(n + 7 + FILT + 4, 2, 4, "R5 slow");
        idle(25); drop_all(); idle(20);

        // R6 bus busy, three blocked cycles on a direct request
        n = cyc; bus_busy = 1;
        set_line(0, 1); push(n + 10, 0, 7, "R6 bus");
        idle(5); bus_busy = 0;
        idle(20); drop_all(); idle(20);

        // R6 sampling disallowed, two blocked cycles on a filtered request
        n = cyc; sample_ok = 0;
        set_line(1, 1); push(n + 7 + FILT + 2, 1, 6, "R6 sample");
        idle(2 + FILT + 2); sample_ok = 1;
        idle(20); drop_all(); idle(20);

        // R7 second request arrives mid-sequence
        n = cyc;
        set_line(0, 1); set_line(1, 1);
        push(n + 7, 0, 4, "R7 first");
        push(n + 13, 1, 4, "R7 pending");
        idle(25); drop_all(); idle(20);

        // R8 same-cycle arrival: direct served before filtered
        n = cyc; set_line(1, 1);
        idle(FILT); set_line(0, 1);
        push(n + FILT + 7, 0, 4, "R8 first");
        push(n + FILT + 13, 1, 4, "R8 second");
        idle(25); drop_all(); idle(25);

        check("R7 scoreboard drained", q.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule